// File: doc/BRIEF.md
# Cross-Clock Machine Timer

This block holds a 64-bit machine time counter and a 64-bit compare value. Both live in a free-running reference clock domain that has no fixed phase relation to the processor clock. The counter advances by one on every reference edge. A level interrupt, registered in the reference domain, is high whenever the counter is at or above the compare value.

The processor reaches the block through a small port in its own clock domain, and that port works in 32-bit halves.

- **Writes.** A write is captured into a holding register. It is announced to the timer domain by flipping a toggle bit, which crosses through a synchronizer. The timer domain applies the write exactly once and returns its own copy of the toggle, which closes the write.
- **Reads.** A read runs a four-phase request/acknowledge handshake. The timer domain freezes a 64-bit snapshot of the counter and then raises the acknowledge. The processor side loads the snapshot while it is frozen, so a read never returns a value caught mid-change.

Top module: `xclk_mtimer`

## Requirements
- R1: Reset sets the counter to zero and the compare value to all ones. It also clears `timer_irq`, `wr_busy`, `rd_busy` and `rd_valid`. With the compare value left at all ones, no interrupt is raised after reset.
- R2: The counter grows by exactly one on each `ref_clk` edge outside reset, unless a write to the counter is applied on that edge. No input can pause it.
- R3: `wr_sel` selects the target half: 0 is the low counter word, 1 the high counter word, 2 the low compare word and 3 the high compare word. A write replaces only the selected 32 bits and leaves the other half as it was.
- R4: An accepted write is applied exactly once in the timer domain. On that edge the written half takes the place of the increment, and counting resumes from the written value on the next edge.
- R5: `wr_busy` rises in the cycle after a write is accepted. It stays high until the timer domain's return toggle has been synchronized back. A `wr_en` pulse seen while `wr_busy` is high is dropped.
- R6: A read proceeds in four steps:
  - `rd_start` raises the request.
  - The timer domain raises the acknowledge only while the request is high.
  - The processor side drops the request only after it has seen the acknowledge.
  - A new request is raised only after the acknowledge has returned low.

  `rd_busy` is high from the cycle after `rd_start` until the acknowledge has been seen low again. A `rd_start` seen while `rd_busy` is high is ignored.
- R7: The returned 64-bit value is the counter value on some reference edge between the raising of the request and the completion of the read. The snapshot does not change while the acknowledge is high.
- R8: `rd_valid` is high for exactly one processor cycle per read. `rd_data` holds the snapshot from that cycle until the next read completes.
- R9: `timer_irq` is high exactly when the counter is greater than or equal to the compare value. It is updated on the same reference edge as the counter or compare value it follows.
- R10: Rewriting the compare value to a value above the counter clears `timer_irq` on the edge that applies the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Processor clock |
| cpu_rst | input | 1 | Synchronous active-high reset, processor domain |
| ref_clk | input | 1 | Timer reference clock |
| ref_rst | input | 1 | Synchronous active-high reset, reference domain |
| wr_en | input | 1 | Write strobe, accepted when `wr_busy` is low |
| wr_sel | input | 2 | Write target half (encoding in R3) |
| wr_data | input | 32 | Write value for the selected half |
| wr_busy | output | 1 | Write in flight |
| rd_start | input | 1 | Start a counter read, accepted when `rd_busy` is low |
| rd_busy | output | 1 | Read handshake in progress |
| rd_valid | output | 1 | One-cycle pulse when `rd_data` is updated |
| rd_data | output | 64 | Last counter snapshot |
| timer_irq | output | 1 | Level interrupt, reference domain |

## Verification
The hardest case to reach is the cycle on which a write lands in the timer domain. That cycle depends on how the two unrelated clocks happen to align, so the bench cannot name it.

The bench does not predict that cycle. It counts reference edges itself and records the edge count when a write is issued and when `wr_busy` falls. From these two counts it keeps a lower and an upper bound on the counter offset. Every later snapshot must fall inside the bounds widened by the read's own request-to-completion window.

The same bounds tell the bench when the counter must have crossed a compare value. It waits for that point, then checks the interrupt as it rises, as it holds, and as it clears on a compare rewrite.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;

    localparam int unsigned TW = 64;          // timer and compare width
    localparam int unsigned HW = TW / 2;      // host access width
    localparam int unsigned SELW = 2;

    typedef enum logic [SELW-1:0] {
        SEL_CNT_LO = 2'd0,
        SEL_CNT_HI = 2'd1,
        SEL_CMP_LO = 2'd2,
        SEL_CMP_HI = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_WAIT_ACK,
        RD_WAIT_DROP
    } rd_state_e;

    typedef struct packed {
        reg_sel_e        sel;
        logic [HW-1:0]   data;
    } wr_cmd_t;

    function automatic logic [TW-1:0] put_half(input logic [TW-1:0] cur,
                                               input logic [HW-1:0] val,
                                               input logic          upper);
        if (upper) put_half = {val, cur[HW-1:0]};
        else       put_half = {cur[TW-1:HW], val};
    endfunction

endpackage

// File: rtl/mtimer_sync.sv
module mtimer_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mtimer_core.sv
module mtimer_core import mtimer_pkg::*; #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          ref_clk,
    input  logic          ref_rst,
    input  logic          wr_tog_a,
    input  wr_cmd_t       wr_cmd_a,
    output logic          wr_seen,
    output logic          wr_apply,
    input  logic          rd_req_a,
    output logic          rd_ack,
    output logic [TW-1:0] snap,
    output logic [TW-1:0] count,
    output logic [TW-1:0] cmp,
    output logic          irq
);
    logic          wr_tog_s;
    logic          req_s;
    logic [TW-1:0] next_count;
    logic [TW-1:0] next_cmp;

    mtimer_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_wr_sync (
        .clk(ref_clk), .rst(ref_rst), .d(wr_tog_a), .q(wr_tog_s));

    mtimer_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_req_sync (
        .clk(ref_clk), .rst(ref_rst), .d(rd_req_a), .q(req_s));

    // A toggle edge marks one pending write; command data is held by the sender.
    assign wr_apply = wr_tog_s ^ wr_seen;

    always_comb begin
        next_count = count + 64'd1;
        next_cmp   = cmp;
        if (wr_apply) begin
            case (wr_cmd_a.sel)
                SEL_CNT_LO: next_count = put_half(count, wr_cmd_a.data, 1'b0);
                SEL_CNT_HI: next_count = put_half(count, wr_cmd_a.data, 1'b1);
                SEL_CMP_LO: next_cmp   = put_half(cmp,   wr_cmd_a.data, 1'b0);
                SEL_CMP_HI: next_cmp   = put_half(cmp,   wr_cmd_a.data, 1'b1);
                default:    next_cmp   = cmp;
            endcase
        end
    end

    always_ff @(posedge ref_clk) begin
        if (ref_rst) begin
            count   <= '0;
            cmp     <= '1;
            irq     <= 1'b0;
            wr_seen <= 1'b0;
            rd_ack  <= 1'b0;
            snap    <= '0;
        end else begin
            count   <= next_count;
            cmp     <= next_cmp;
            irq     <= (next_count >= next_cmp);
            wr_seen <= wr_tog_s;
            if (req_s && !rd_ack) begin
                snap   <= count;
                rd_ack <= 1'b1;
            end else if (!req_s) begin
                rd_ack <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/mtimer_cpu_port.sv
module mtimer_cpu_port import mtimer_pkg::*; #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          cpu_clk,
    input  logic          cpu_rst,
    input  logic          wr_en,
    input  logic [SELW-1:0] wr_sel,
    input  logic [HW-1:0] wr_data,
    output logic          wr_busy,
    output logic          wr_tog,
    output wr_cmd_t       wr_cmd,
    input  logic          wr_seen_a,
    input  logic          rd_start,
    output logic          rd_busy,
    output logic          rd_valid,
    output logic [TW-1:0] rd_data,
    output logic          rd_req,
    input  logic          rd_ack_a,
    input  logic [TW-1:0] snap_a
);
    logic      seen_s;
    logic      ack_s;
    rd_state_e st;

    mtimer_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_seen_sync (
        .clk(cpu_clk), .rst(cpu_rst), .d(wr_seen_a), .q(seen_s));

    mtimer_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_ack_sync (
        .clk(cpu_clk), .rst(cpu_rst), .d(rd_ack_a), .q(ack_s));

    assign wr_busy = wr_tog ^ seen_s;
    assign rd_busy = (st != RD_IDLE);

    always_ff @(posedge cpu_clk) begin
        if (cpu_rst) begin
            wr_tog      <= 1'b0;
            wr_cmd.sel  <= SEL_CNT_LO;
            wr_cmd.data <= '0;
        end else if (wr_en && !wr_busy) begin
            wr_tog      <= ~wr_tog;
            wr_cmd.sel  <= reg_sel_e'(wr_sel);
            wr_cmd.data <= wr_data;
        end
    end

    always_ff @(posedge cpu_clk) begin
        if (cpu_rst) begin
            st       <= RD_IDLE;
            rd_req   <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= 1'b0;
            case (st)
                RD_IDLE: if (rd_start) begin
                    rd_req <= 1'b1;
                    st     <= RD_WAIT_ACK;
                end
                RD_WAIT_ACK: if (ack_s) begin
                    rd_data  <= snap_a;     // frozen while ack is high
                    rd_valid <= 1'b1;
                    rd_req   <= 1'b0;
                    st       <= RD_WAIT_DROP;
                end
                RD_WAIT_DROP: if (!ack_s) st <= RD_IDLE;
                default: st <= RD_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/xclk_mtimer.sv
module xclk_mtimer import mtimer_pkg::*; #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          cpu_clk,
    input  logic          cpu_rst,
    input  logic          ref_clk,
    input  logic          ref_rst,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [31:0]   wr_data,
    output logic          wr_busy,
    input  logic          rd_start,
    output logic          rd_busy,
    output logic          rd_valid,
    output logic [63:0]   rd_data,
    output logic          timer_irq
);
    logic          wr_tog;
    logic          wr_seen;
    logic          wr_apply;
    wr_cmd_t       wr_cmd;
    logic          rd_req;
    logic          rd_ack;
    logic [TW-1:0] snap;
    logic [TW-1:0] count;
    logic [TW-1:0] cmp;

    mtimer_cpu_port #(.SYNC_STAGES(SYNC_STAGES)) i_cpu (
        .cpu_clk(cpu_clk), .cpu_rst(cpu_rst),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .wr_busy(wr_busy),
        .wr_tog(wr_tog), .wr_cmd(wr_cmd), .wr_seen_a(wr_seen),
        .rd_start(rd_start), .rd_busy(rd_busy), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_req(rd_req), .rd_ack_a(rd_ack), .snap_a(snap));

    mtimer_core #(.SYNC_STAGES(SYNC_STAGES)) i_core (
        .ref_clk(ref_clk), .ref_rst(ref_rst),
        .wr_tog_a(wr_tog), .wr_cmd_a(wr_cmd), .wr_seen(wr_seen), .wr_apply(wr_apply),
        .rd_req_a(rd_req), .rd_ack(rd_ack), .snap(snap),
        .count(count), .cmp(cmp), .irq(timer_irq));
endmodule

// File: rtl/mtimer_checker.sv
module mtimer_checker import mtimer_pkg::*; (
    input logic          cpu_clk,
    input logic          cpu_rst,
    input logic          ref_clk,
    input logic          ref_rst,
    input logic          wr_en,
    input logic          wr_busy,
    input logic          wr_tog,
    input logic          wr_apply,
    input wr_cmd_t       wr_cmd,
    input logic          rd_req,
    input logic          rd_ack,
    input logic          rd_valid,
    input logic [TW-1:0] snap,
    input logic [TW-1:0] count,
    input logic [TW-1:0] cmp,
    input logic          irq
);
    // R2: plain increment when no write lands
    a_r2_tick: assert property (@(posedge ref_clk) disable iff (ref_rst)
        !wr_apply |=> count == $past(count) + 64'd1);

    // R4: written low half replaces the increment
    a_r4_write_wins: assert property (@(posedge ref_clk) disable iff (ref_rst)
        (wr_apply && wr_cmd.sel == SEL_CNT_LO) |=> count[HW-1:0] == $past(wr_cmd.data));

    // R4: one toggle edge yields one application
    a_r4_apply_once: assert property (@(posedge ref_clk) disable iff (ref_rst)
        wr_apply |=> !wr_apply);

    // R5: strobes while busy leave the write toggle alone
    a_r5_busy_drop: assert property (@(posedge cpu_clk) disable iff (cpu_rst)
        (wr_en && wr_busy) |=> $stable(wr_tog));

    // R6: ack only answers a raised request
    a_r6_ack_after_req: assert property (@(posedge ref_clk) disable iff (ref_rst)
        $rose(rd_ack) |-> rd_req);

    // R6: request drops only once ack is up
    a_r6_req_drop_after_ack: assert property (@(posedge cpu_clk) disable iff (cpu_rst)
        $fell(rd_req) |-> rd_ack);

    // R6: new request only after ack returned low
    a_r6_req_after_ack_low: assert property (@(posedge cpu_clk) disable iff (cpu_rst)
        $rose(rd_req) |-> !rd_ack);

    // R7: snapshot frozen while ack is held
    a_r7_snap_stable: assert property (@(posedge ref_clk) disable iff (ref_rst)
        (rd_ack && $past(rd_ack)) |-> $stable(snap));

    // R8: valid lasts one cycle
    a_r8_valid_pulse: assert property (@(posedge cpu_clk) disable iff (cpu_rst)
        rd_valid |=> !rd_valid);

    // R9: interrupt level tracks the comparison
    a_r9_irq_level: assert property (@(posedge ref_clk) disable iff (ref_rst)
        irq == (count >= cmp));
endmodule

bind xclk_mtimer mtimer_checker i_chk (
    .cpu_clk(cpu_clk), .cpu_rst(cpu_rst), .ref_clk(ref_clk), .ref_rst(ref_rst),
    .wr_en(wr_en), .wr_busy(wr_busy), .wr_tog(wr_tog), .wr_apply(wr_apply),
    .wr_cmd(wr_cmd), .rd_req(rd_req), .rd_ack(rd_ack), .rd_valid(rd_valid),
    .snap(snap), .count(count), .cmp(cmp), .irq(timer_irq));

// File: tb/test_xclk_mtimer.sv
`timescale 1ns/1ps
module test_xclk_mtimer;

    logic        cpu_clk = 1'b0;
    logic        ref_clk = 1'b0;
    logic        cpu_rst = 1'b1;
    logic        ref_rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic        rd_start = 1'b0;
    logic        wr_busy, rd_busy, rd_valid, timer_irq;
    logic [63:0] rd_data;

    int     n_cmp = 0;
    int     n_bad = 0;
    bit     done = 1'b0;
    logic [63:0] rtick = '0;
    longint off_lo = 0;
    longint off_hi = 0;

    always #10 cpu_clk = ~cpu_clk;   // 50 MHz
    always #17 ref_clk = ~ref_clk;   // unrelated reference

    always @(posedge ref_clk) begin
        if (ref_rst) rtick <= '0;
        else         rtick <= rtick + 64'd1;
    end

    xclk_mtimer i_xclk_mtimer (
        .cpu_clk(cpu_clk), .cpu_rst(cpu_rst), .ref_clk(ref_clk), .ref_rst(ref_rst),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .wr_busy(wr_busy),
        .rd_start(rd_start), .rd_busy(rd_busy), .rd_valid(rd_valid),
        .rd_data(rd_data), .timer_irq(timer_irq));

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic longint now_tick();
        return longint'(rtick);
    endfunction

    task automatic do_write(input logic [1:0] sel, input logic [31:0] d,
                            output longint t0, output longint t1);
        @(negedge cpu_clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d; t0 = now_tick();
        @(negedge cpu_clk);
        wr_en = 1'b0;
        while (wr_busy) @(negedge cpu_clk);
        t1 = now_tick();
    endtask

    // counter = {hi, lo} afterwards; offset bounds follow from the write window
    task automatic set_count(input logic [31:0] hi, input logic [31:0] lo);
        longint t0, t1;
        do_write(2'd1, hi, t0, t1);
        do_write(2'd0, lo, t0, t1);
        off_lo = longint'({hi, lo}) - t1 - 1;
        off_hi = longint'({hi, lo}) - t0 + 1;
    endtask

    task automatic do_read(output logic [63:0] v, output longint tq, output longint td);
        @(negedge cpu_clk);
        rd_start = 1'b1; tq = now_tick();
        @(negedge cpu_clk);
        rd_start = 1'b0;
        while (!rd_valid) @(negedge cpu_clk);
        td = now_tick();
        v = rd_data;
    endtask

    task automatic read_in_range(input string req);
        logic [63:0] v;
        longint tq, td, lo, hi;
        do_read(v, tq, td);
        lo = tq + off_lo;
        hi = td + off_hi;
        check(longint'(v) >= lo && longint'(v) <= hi, req, "snapshot below window", v, 64'(lo));
        while (rd_busy) @(negedge cpu_clk);
    endtask

    initial begin
        logic [63:0] v;
        longint tq, td, t0, t1, cmpv;
        int pulses;
        void'($urandom(32'h5EED_0042));

        repeat (5) @(negedge cpu_clk);
        // R1: state held in reset
        check(timer_irq == 1'b0, "R1", "irq in reset", 64'(timer_irq), 64'd0);
        check(wr_busy == 1'b0 && rd_busy == 1'b0, "R1", "busy in reset",
              64'({wr_busy, rd_busy}), 64'd0);
        check(rd_valid == 1'b0, "R1", "valid in reset", 64'(rd_valid), 64'd0);
        cpu_rst = 1'b0; ref_rst = 1'b0;

        // R1: compare at all ones keeps the interrupt low
        repeat (100) @(negedge cpu_clk);
        check(timer_irq == 1'b0, "R1", "irq after reset", 64'(timer_irq), 64'd0);

        // R1, R2: counter started at zero, one per reference edge
        off_lo = -1; off_hi = 1;
        read_in_range("R2");

        // R7, R8: reads with random gaps
        for (int k = 0; k < 6; k++) begin
            repeat ($urandom_range(0, 12)) @(negedge cpu_clk);
            do_read(v, tq, td);
            check(longint'(v) >= tq + off_lo && longint'(v) <= td + off_hi,
                  "R7", "snapshot window", v, 64'(tq + off_lo));
            @(negedge cpu_clk);
            check(rd_valid == 1'b0, "R8", "valid width", 64'(rd_valid), 64'd0);
            check(rd_data == v, "R8", "data held", rd_data, v);
            while (rd_busy) @(negedge cpu_clk);
        end

        // R6: a second start during a handshake is ignored
        @(negedge cpu_clk); rd_start = 1'b1;
        @(negedge cpu_clk); rd_start = 1'b0;
        check(rd_busy == 1'b1, "R6", "busy after start", 64'(rd_busy), 64'd1);
        @(negedge cpu_clk); rd_start = 1'b1;
        @(negedge cpu_clk); rd_start = 1'b0;
        pulses = 0;
        for (int k = 0; k < 60; k++) begin
            @(negedge cpu_clk);
            if (rd_valid) pulses++;
        end
        check(pulses == 1, "R6", "completions for overlapping start", 64'(pulses), 64'd1);
        check(rd_busy == 1'b0, "R6", "busy after completion", 64'(rd_busy), 64'd0);

        // R3, R4: random low-word counter writes
        for (int k = 0; k < 6; k++) begin
            logic [31:0] val;
            val = $urandom_range(0, 32'h3FFF_FFFF);
            do_write(2'd0, val, t0, t1);
            off_lo = longint'(val) - t1 - 1;
            off_hi = longint'(val) - t0 + 1;
            read_in_range("R4");
        end

        // R3: high word write leaves a split value
        set_count(32'd5, 32'd1000);
        do_read(v, tq, td);
        check(v[63:32] == 32'd5, "R3", "high word", 64'(v[63:32]), 64'd5);
        check(longint'(v) >= tq + off_lo && longint'(v) <= td + off_hi,
              "R3", "full value", v, 64'(tq + off_lo));
        while (rd_busy) @(negedge cpu_clk);

        // R5: second strobe while busy is dropped
        set_count(32'd0, 32'd0);
        @(negedge cpu_clk);
        wr_en = 1'b1; wr_sel = 2'd0; wr_data = 32'd2000; t0 = now_tick();
        @(negedge cpu_clk);
        check(wr_busy == 1'b1, "R5", "busy after accept", 64'(wr_busy), 64'd1);
        wr_data = 32'h2000_0000;
        @(negedge cpu_clk);
        wr_en = 1'b0;
        while (wr_busy) @(negedge cpu_clk);
        t1 = now_tick();
        off_lo = 2000 - t1 - 1;
        off_hi = 2000 - t0 + 1;
        read_in_range("R5");

        // R9, R10: compare crossings
        set_count(32'd0, 32'd100);
        do_write(2'd3, 32'd0, t0, t1);
        check(timer_irq == 1'b0, "R9", "irq below high-cleared compare", 64'(timer_irq), 64'd0);
        cmpv = now_tick() + off_hi + 300;
        do_write(2'd2, cmpv[31:0], t0, t1);
        check(timer_irq == 1'b0, "R9", "irq before crossing", 64'(timer_irq), 64'd0);
        while (now_tick() + off_lo < cmpv + 3) @(negedge cpu_clk);
        check(timer_irq == 1'b1, "R9", "irq after crossing", 64'(timer_irq), 64'd1);
        repeat (10) @(negedge cpu_clk);
        check(timer_irq == 1'b1, "R9", "irq level holds", 64'(timer_irq), 64'd1);
        cmpv = cmpv + 100000;
        do_write(2'd2, cmpv[31:0], t0, t1);
        check(timer_irq == 1'b0, "R10", "irq after raising compare", 64'(timer_irq), 64'd0);
        do_write(2'd2, 32'd5, t0, t1);
        check(timer_irq == 1'b1, "R9", "irq after lowering compare", 64'(timer_irq), 64'd1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #3000000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R6 watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule